// File: doc/BRIEF.md
# Jittered Foldback Switching Oscillator

This block is the timing source for an on/off controlled power stage. A phase accumulator advances by a frequency word on every clock. Each time it wraps, the block issues a one-clock cycle-start pulse, and the power-stage controller decides at that pulse whether to conduct for the coming period. A maximum-duty window output stays high for a fixed fraction of each period, measured from the pulse. The controller uses it to force the switch off before the period ends.

The frequency word is built in two layers. First, a digitized feedback code folds the nominal word back. At or above the regulation code the full nominal word is used. Between the regulation code and the lower knee code, the word falls linearly to 48% of nominal. Below the knee it stays at that floor. Second, a slow triangular modulation spreads the word around its folded value to lower conducted emissions. The modulation depth is a fixed fraction of the folded word, so the spread shrinks when the frequency is folded back. The triangle repeats at a parameterized rate, 1 kHz by default.

Top module: `jitter_osc`

## Requirements
- R1: While `rst` is high, at the next clock edge `freq_word`, `cyc_start` and `max_duty` all become 0.
- R2: For `fb_code` >= FB_HI_CODE (default 524) the folded word equals NOM_WORD (default 1024).
- R3: For FB_LO_CODE < `fb_code` < FB_HI_CODE the folded word is NOM_WORD - (((FB_HI_CODE - fb_code) * SLOPE) >> 12), where SLOPE = floor(((NOM_WORD - FLOOR) << 12) / (FB_HI_CODE - FB_LO_CODE)).
- R4: For `fb_code` <= FB_LO_CODE (default 248) the folded word is FLOOR = floor(NOM_WORD * 48 / 100), which is 491 by default. The folded word never leaves the range [FLOOR, NOM_WORD].
- R5: `freq_word` = fold + ((amp * pos) >> 6) - (amp >> 1). Here amp = (fold * 13) >> 8, which is about 5% peak to peak, and pos is a triangle position in 0..64. Over one modulation period, `freq_word` reaches both fold - (amp >> 1) and fold + amp - (amp >> 1).
- R6: The triangle position starts at 0 after reset and moves by one step every DIV = CLK_HZ / (JIT_HZ * 128) clocks, running 0 up to 64 and back down. One full modulation period is therefore 128 * DIV clocks.
- R7: A change of `fb_code` reaches `freq_word` exactly three clock edges later.
- R8: `cyc_start` is one clock wide. It pulses when the 16-bit phase accumulator (which adds `freq_word` every clock) carries out. Pulse spacing lies between floor(65536 / wmax) and ceil(65536 / wmin) clocks, where wmin and wmax are the smallest and largest frequency words in use.
- R9: `max_duty` is high while the updated phase is below DMAX = floor(65536 * 65 / 100). It is high in every `cyc_start` cycle. The number of high cycles per period lies between floor(DMAX / wmax) and floor(DMAX / wmin) + 1.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_code | input | FB_W (10) | Unsigned digitized feedback voltage |
| cyc_start | output | 1 | One-clock pulse at the start of each switching period |
| max_duty | output | 1 | High during the allowed conduction window of the period |
| freq_word | output | ACC_W (16) | Current frequency word (folded and jittered) |

## Verification
The bench targets the edges of the foldback curve:
- the code exactly at the regulation threshold and one below it, where an off-by-one comparison would start folding early or late;
- the knee code and codes below it, where a missing clamp would drive the word under the 48% floor or make it wrap.

For the jitter, the bench measures the extreme words at full and folded frequency. A spread tied to the nominal word instead of the folded word would show the same depth in both cases. A wrong triangle step count would stretch or shorten the measured modulation period.

For latency, the bench counts edges from a feedback step, which exposes a missing or extra pipeline stage. For the pulse train, it checks that pulses are isolated, that the gaps lie within bounds, and that the duty window is high at each pulse and covers the expected count. A window measured from the wrong phase would fail one of these.

// File: rtl/osc_pkg.sv
package osc_pkg;

  // fixed-point fraction bits used by the foldback slope
  localparam int unsigned SLOPE_SH = 12;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } tri_dir_e;

  // integer percent of a value, rounded down
  function automatic longint unsigned pct_of(longint unsigned value, int unsigned pct);
    return (value * longint'(pct)) / 100;
  endfunction

endpackage

// File: rtl/osc_foldback.sv
module osc_foldback
  import osc_pkg::*;
#(
  parameter int unsigned FB_W       = 10,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned NOM_WORD   = 1024,
  parameter int unsigned FB_HI_CODE = 524,
  parameter int unsigned FB_LO_CODE = 248,
  parameter int unsigned FLOOR_PCT  = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FB_W-1:0]   fb_code,
  output logic [WORD_W-1:0] fold_word
);

  localparam longint unsigned FLOOR_WORD = pct_of(longint'(NOM_WORD), FLOOR_PCT);
  localparam longint unsigned SPAN       = longint'(FB_HI_CODE - FB_LO_CODE);
  localparam longint unsigned SLOPE      =
    ((longint'(NOM_WORD) - FLOOR_WORD) << SLOPE_SH) / SPAN;

  logic [FB_W-1:0]   fb_q;
  logic [FB_W-1:0]   deficit;
  logic [63:0]       prod;
  logic [63:0]       drop;
  logic [WORD_W-1:0] fold_n;

  // stage 1: capture the feedback code
  always_ff @(posedge clk) begin
    if (rst) fb_q <= '0;
    else     fb_q <= fb_code;
  end

  // linear segment with a constant multiply, no divider in hardware
  always_comb begin
    deficit = FB_W'(FB_HI_CODE) - fb_q;
    prod    = 64'(deficit) * 64'(SLOPE);
    drop    = prod >> SLOPE_SH;
    if (fb_q >= FB_W'(FB_HI_CODE))
      fold_n = WORD_W'(NOM_WORD);
    else if (fb_q <= FB_W'(FB_LO_CODE))
      fold_n = WORD_W'(FLOOR_WORD);
    else
      fold_n = WORD_W'(NOM_WORD) - WORD_W'(drop);
  end

  // stage 2: folded word
  always_ff @(posedge clk) begin
    if (rst) fold_word <= WORD_W'(NOM_WORD);
    else     fold_word <= fold_n;
  end

  p_fold_range_r4: assert property (@(posedge clk) disable iff (rst)
    (fold_word >= WORD_W'(FLOOR_WORD)) && (fold_word <= WORD_W'(NOM_WORD)))
    else $error("folded word outside floor..nominal");

  p_fold_full_r2: assert property (@(posedge clk) disable iff (rst)
    (fb_q >= FB_W'(FB_HI_CODE)) |=> (fold_word == WORD_W'(NOM_WORD)))
    else $error("regulation-level feedback did not give the nominal word");

endmodule

// File: rtl/osc_jitter.sv
module osc_jitter
  import osc_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned TRI_W   = 6,
  parameter int unsigned JIT_NUM = 13,
  parameter int unsigned JIT_SH  = 8,
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned JIT_HZ  = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] fold_word,
  output logic [WORD_W-1:0] freq_word
);

  localparam int unsigned TRI_MAX = 2 ** TRI_W;
  localparam int unsigned DIV_RAW = CLK_HZ / (JIT_HZ * 2 * TRI_MAX);
  localparam int unsigned DIV_N   = (DIV_RAW < 1) ? 1 : DIV_RAW;
  localparam int unsigned DIV_W   = $clog2(DIV_N + 1);

  logic [DIV_W-1:0] div_q;
  logic [TRI_W:0]   tri_pos;
  tri_dir_e         dir_q;
  logic             step;

  logic [63:0]       amp;
  logic [63:0]       off_pos;
  logic [63:0]       sum;
  logic [WORD_W-1:0] freq_n;

  assign step = (div_q == DIV_W'(DIV_N - 1));

  // triangle position: 0 .. TRI_MAX .. 0, one step per DIV_N clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      tri_pos <= '0;
      dir_q   <= DIR_UP;
    end else if (step) begin
      div_q <= '0;
      if (dir_q == DIR_UP) begin
        if (tri_pos == (TRI_W+1)'(TRI_MAX)) begin
          dir_q   <= DIR_DOWN;
          tri_pos <= (TRI_W+1)'(TRI_MAX - 1);
        end else begin
          tri_pos <= tri_pos + 1'b1;
        end
      end else begin
        if (tri_pos == '0) begin
          dir_q   <= DIR_UP;
          tri_pos <= (TRI_W+1)'(1);
        end else begin
          tri_pos <= tri_pos - 1'b1;
        end
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // depth scales with the folded word; centred on it
  always_comb begin
    amp     = (64'(fold_word) * 64'(JIT_NUM)) >> JIT_SH;
    off_pos = (amp * 64'(tri_pos)) >> TRI_W;
    sum     = 64'(fold_word) + off_pos - (amp >> 1);
    freq_n  = WORD_W'(sum);
  end

  // stage 3: output word
  always_ff @(posedge clk) begin
    if (rst) freq_word <= '0;
    else     freq_word <= freq_n;
  end

  p_tri_step_r6: assert property (@(posedge clk) disable iff (rst)
    (tri_pos == $past(tri_pos)) || (tri_pos == $past(tri_pos) + 1'b1) ||
    (tri_pos == $past(tri_pos) - 1'b1))
    else $error("triangle position jumped");

  p_tri_bound_r5: assert property (@(posedge clk) disable iff (rst)
    tri_pos <= (TRI_W+1)'(TRI_MAX))
    else $error("triangle position past its peak");

endmodule

// File: rtl/osc_phase.sv
module osc_phase #(
  parameter int unsigned ACC_W    = 16,
  parameter int unsigned DUTY_PCT = 65
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] word,
  output logic             cyc_start,
  output logic             max_duty
);

  localparam longint unsigned FULL   = 64'd1 << ACC_W;
  localparam longint unsigned DMAX   = (FULL * longint'(DUTY_PCT)) / 100;
  localparam longint unsigned HALF   = FULL >> 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   acc_sum;

  assign acc_sum = {1'b0, acc_q} + {1'b0, word};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      cyc_start <= 1'b0;
      max_duty  <= 1'b0;
    end else begin
      acc_q     <= acc_sum[ACC_W-1:0];
      cyc_start <= acc_sum[ACC_W];
      max_duty  <= (64'(acc_sum[ACC_W-1:0]) < DMAX);
    end
  end

  p_pulse_narrow_r8: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && (64'(word) < HALF)) |=> !cyc_start)
    else $error("cycle-start pulse wider than one clock");

  p_duty_at_start_r9: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && (64'($past(word)) < DMAX)) |-> max_duty)
    else $error("duty window low at cycle start");

endmodule

// File: rtl/jitter_osc.sv
module jitter_osc #(
  parameter int unsigned ACC_W      = 16,
  parameter int unsigned FB_W       = 10,
  parameter int unsigned NOM_WORD   = 1024,
  parameter int unsigned FB_HI_CODE = 524,
  parameter int unsigned FB_LO_CODE = 248,
  parameter int unsigned FLOOR_PCT  = 48,
  parameter int unsigned JIT_NUM    = 13,
  parameter int unsigned JIT_SH     = 8,
  parameter int unsigned TRI_W      = 6,
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned JIT_HZ     = 1000,
  parameter int unsigned DUTY_PCT   = 65
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FB_W-1:0]  fb_code,
  output logic             cyc_start,
  output logic             max_duty,
  output logic [ACC_W-1:0] freq_word
);

  logic [ACC_W-1:0] fold_word;

  osc_foldback #(
    .FB_W       (FB_W),
    .WORD_W     (ACC_W),
    .NOM_WORD   (NOM_WORD),
    .FB_HI_CODE (FB_HI_CODE),
    .FB_LO_CODE (FB_LO_CODE),
    .FLOOR_PCT  (FLOOR_PCT)
  ) u_fold (
    .clk       (clk),
    .rst       (rst),
    .fb_code   (fb_code),
    .fold_word (fold_word)
  );

  osc_jitter #(
    .WORD_W  (ACC_W),
    .TRI_W   (TRI_W),
    .JIT_NUM (JIT_NUM),
    .JIT_SH  (JIT_SH),
    .CLK_HZ  (CLK_HZ),
    .JIT_HZ  (JIT_HZ)
  ) u_jit (
    .clk       (clk),
    .rst       (rst),
    .fold_word (fold_word),
    .freq_word (freq_word)
  );

  osc_phase #(
    .ACC_W    (ACC_W),
    .DUTY_PCT (DUTY_PCT)
  ) u_phase (
    .clk       (clk),
    .rst       (rst),
    .word      (freq_word),
    .cyc_start (cyc_start),
    .max_duty  (max_duty)
  );

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (freq_word == '0) && !cyc_start && !max_duty)
    else $error("outputs not cleared by reset");

endmodule

// File: tb/sim_jitter_osc.sv
module sim_jitter_osc;

  localparam int unsigned ACC_W   = 16;
  localparam int unsigned FB_W    = 10;
  localparam int unsigned NOM     = 1024;
  localparam int unsigned FB_HI   = 524;
  localparam int unsigned FB_LO   = 248;
  localparam int unsigned CLK_HZ  = 12_800_000;
  localparam int unsigned JIT_HZ  = 1000;
  localparam int unsigned DIV     = CLK_HZ / (JIT_HZ * 128);
  localparam int unsigned FLOOR   = NOM * 48 / 100;
  localparam int unsigned SLOPE   = ((NOM - FLOOR) << 12) / (FB_HI - FB_LO);
  localparam int unsigned DMAX    = 65536 * 65 / 100;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [FB_W-1:0]  fb_code = '0;
  logic             cyc_start;
  logic             max_duty;
  logic [ACC_W-1:0] freq_word;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  jitter_osc #(
    .ACC_W  (ACC_W),
    .FB_W   (FB_W),
    .CLK_HZ (CLK_HZ),
    .JIT_HZ (JIT_HZ)
  ) u0 (
    .clk       (clk),
    .rst       (rst),
    .fb_code   (fb_code),
    .cyc_start (cyc_start),
    .max_duty  (max_duty),
    .freq_word (freq_word)
  );

  function automatic int ref_fold(int fb);
    if (fb >= FB_HI) return NOM;
    if (fb <= FB_LO) return FLOOR;
    return NOM - (((FB_HI - fb) * SLOPE) >> 12);
  endfunction

  function automatic int ref_amp(int fold);
    return (fold * 13) >> 8;
  endfunction

  function automatic int ref_min(int fb);
    return ref_fold(fb) - (ref_amp(ref_fold(fb)) >> 1);
  endfunction

  function automatic int ref_max(int fb);
    return ref_fold(fb) + ref_amp(ref_fold(fb)) - (ref_amp(ref_fold(fb)) >> 1);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int fb);
    rst     = 1'b1;
    fb_code = FB_W'(fb);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // R1: outputs cleared while reset is held
  task automatic t_reset();
    do_reset(1023);
    repeat (200) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(freq_word == 0, "R1 freq_word", int'(freq_word), 0);
    check(cyc_start == 0, "R1 cyc_start", int'(cyc_start), 0);
    check(max_duty == 0, "R1 max_duty", int'(max_duty), 0);
  endtask

  // R2/R3/R4: word at triangle position 0 just after reset
  task automatic t_fold(input int fb, input string tag);
    do_reset(fb);
    repeat (6) @(negedge clk);
    check(int'(freq_word) == ref_min(fb), tag, int'(freq_word), ref_min(fb));
  endtask

  // R7: three-edge latency from fb_code to freq_word
  task automatic t_latency();
    do_reset(1023);
    repeat (10) @(negedge clk);
    fb_code = FB_W'(FB_LO);
    repeat (2) @(negedge clk);
    check(int'(freq_word) == ref_min(1023), "R7 before third edge",
          int'(freq_word), ref_min(1023));
    @(negedge clk);
    check(int'(freq_word) == ref_min(FB_LO), "R7 at third edge",
          int'(freq_word), ref_min(FB_LO));
  endtask

  // R5: extremes of the spread, scaled by the folded word
  task automatic t_jitter(input int fb, input string tag);
    int lo = 65535;
    int hi = 0;
    do_reset(fb);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 128 * DIV + 50; i++) begin
      @(negedge clk);
      if (int'(freq_word) < lo) lo = int'(freq_word);
      if (int'(freq_word) > hi) hi = int'(freq_word);
    end
    check(lo == ref_min(fb), {tag, " min"}, lo, ref_min(fb));
    check(hi == ref_max(fb), {tag, " max"}, hi, ref_max(fb));
  endtask

  // R6: modulation period
  task automatic t_period();
    int t = 0;
    int first = -1;
    int second = -1;
    int prev;
    int mn = ref_min(1023);
    do_reset(1023);
    repeat (4) @(negedge clk);
    prev = int'(freq_word);
    while (second < 0 && t < 3 * 128 * DIV) begin
      @(negedge clk);
      t++;
      if (prev == mn && int'(freq_word) > mn) begin
        if (first < 0) first = t;
        else second = t;
      end
      prev = int'(freq_word);
    end
    check(second - first == 128 * DIV, "R6 modulation period", second - first, 128 * DIV);
  endtask

  // R8/R9: pulse shape, spacing and duty window
  task automatic t_pulses(input int fb, input string tag);
    int wmin = ref_min(fb);
    int wmax = ref_max(fb);
    int glo  = 65536 / wmax;
    int ghi  = (65536 + wmin - 1) / wmin;
    int dlo  = DMAX / wmax;
    int dhi  = DMAX / wmin + 1;
    bit started = 0;
    bit prev_cs = 0;
    int gap = 0;
    int dc = 0;
    int pulses = 0;
    do_reset(fb);
    repeat (6) @(negedge clk);
    for (int i = 0; i < 30 * ghi; i++) begin
      @(negedge clk);
      if (cyc_start) begin
        check(!prev_cs, {"R8 pulse width ", tag}, 2, 1);
        check(max_duty == 1'b1, {"R9 window at start ", tag}, int'(max_duty), 1);
        if (started) begin
          check(gap >= glo && gap <= ghi, {"R8 spacing ", tag}, gap, glo);
          check(dc >= dlo && dc <= dhi, {"R9 window length ", tag}, dc, dlo);
          pulses++;
        end
        started = 1;
        gap = 1;
        dc = max_duty ? 1 : 0;
      end else if (started) begin
        gap++;
        if (max_duty) dc++;
      end
      prev_cs = cyc_start;
    end
    check(pulses >= 20, {"R8 pulse count ", tag}, pulses, 20);
  endtask

  initial begin
    t_reset();
    t_fold(1023, "R2 top code");
    t_fold(FB_HI, "R2 at threshold");
    t_fold(FB_HI - 1, "R3 one below threshold");
    t_fold(386, "R3 mid segment");
    t_fold(FB_LO + 1, "R3 one above knee");
    t_fold(FB_LO, "R4 at knee");
    t_fold(0, "R4 zero code");
    t_latency();
    t_jitter(1023, "R5 full");
    t_jitter(100, "R5 folded");
    t_period();
    t_pulses(1023, "full");
    t_pulses(FB_LO, "floor");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule